// File: doc/BRIEF.md
# Controller Command and Status Register

This block is the single host-visible control word of a small Ethernet controller. One 16-bit location serves two purposes: a host write is decoded as a command, and a host read returns the current status. The command word loads the interrupt masks. It acknowledges pending interrupt events. It starts or stops the DMA request logic, the packet receiver and the transmitter. It also selects the direction of the packet buffer FIFO.

Event pulses from the DMA, receive, transmit and window logic set the pending flags. One interrupt line is raised while any pending flag has its enable set. The FIFO full and empty inputs are passed through into the status word. The MAC datapath, the DMA engine and the FIFO storage live outside this block.

All state changes on the rising clock edge that samples `cmd_wr_i` or an event. `status_o`, `irq_o`, `run_on_o` and `fifo_rd_dir_o` show the new state right after that edge.

Top module: `nic_cmd_stat`

## Requirements
- R1: While `rst_ni` is low, the enables, pending flags and run flags are all 0, the FIFO direction is write (status bit 15 = 0), and `irq_o` is 0.
- R2: Each command write loads command bits 3:0 into the interrupt enables (bit 0 DMA, bit 1 receive, bit 2 transmit, bit 3 window), and these appear in status bits 3:0.
- R3: Command bits 7:4 acknowledge the pending flags in status bits 7:4, in the same source order. Writing 0x00F0 clears all four.
- R4: A pulse on `evt_i[k]` sets pending flag k. If an event and an acknowledge for the same flag fall in the same cycle, the flag stays set.
- R5: Command bits 10:8 turn on DMA, receive and transmit, and bits 13:11 turn the same three off. When both bits for one function are written together, the function ends up off. The state is shown in status bits 10:8 and on `run_on_o`.
- R6: Command bit 14 selects FIFO read direction and bit 15 selects write direction. If both are set, write wins. Status bit 15 and `fifo_rd_dir_o` read 1 for read and 0 for write.
- R7: Status bit 13 follows `fifo_full_i`, status bit 14 follows `fifo_empty_i`, and status bits 12:11 read 0.
- R8: `irq_o` is 1 exactly when some pending flag and its matching enable are both 1.
- R9: In a cycle with no command write, the enables, run flags and FIFO direction hold, and pending flags only change because of events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_wr_i | input | 1 | Host write strobe for the command word |
| cmd_i | input | 16 | Command word |
| evt_i | input | 4 | Event pulses: 0 DMA, 1 receive, 2 transmit, 3 window |
| fifo_full_i | input | 1 | Buffer FIFO full |
| fifo_empty_i | input | 1 | Buffer FIFO empty |
| status_o | output | 16 | Status word returned on a host read |
| irq_o | output | 1 | Combined interrupt request |
| run_on_o | output | 3 | Run state: 0 DMA, 1 receive, 2 transmit |
| fifo_rd_dir_o | output | 1 | FIFO direction, 1 = read |

## Verification
Two functions can meet in one cycle: an event pulse from the datapath and a host acknowledge for the same pending flag. The bench provokes this by driving the transmit event and a command with the transmit acknowledge bit in the same cycle. It then expects the flag to still be set one edge later. In the same spirit, it writes set and clear bits for one run function together, and both FIFO direction bits together. It expects the stop, and the write direction, to win.

// File: rtl/nic_cs_pkg.sv
package nic_cs_pkg;
  localparam int unsigned WORD_W  = 16;
  localparam int unsigned NUM_SRC = 4;
  localparam int unsigned NUM_RUN = 3;

  // command layout, MSB first
  typedef struct packed {
    logic               to_wr;
    logic               to_rd;
    logic [NUM_RUN-1:0] run_clr;
    logic [NUM_RUN-1:0] run_set;
    logic [NUM_SRC-1:0] ack;
    logic [NUM_SRC-1:0] en;
  } cmd_t;

  // status layout, MSB first
  typedef struct packed {
    logic               rd_dir;
    logic               empty;
    logic               full;
    logic [1:0]         rsvd;
    logic [NUM_RUN-1:0] run_on;
    logic [NUM_SRC-1:0] pend;
    logic [NUM_SRC-1:0] en;
  } stat_t;
endpackage

// File: rtl/nic_cs_irq_bank.sv
module nic_cs_irq_bank #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [N-1:0] en_i,
  input  logic [N-1:0] ack_i,
  input  logic [N-1:0] evt_i,
  output logic [N-1:0] en_o,
  output logic [N-1:0] pend_o,
  output logic         irq_o
);
  logic [N-1:0] en_q, pend_q;

  for (genvar g = 0; g < N; g++) begin : g_src
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   en_q[g] <= 1'b0;
      else if (wr_i) en_q[g] <= en_i[g];
    end

    // event beats acknowledge
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                pend_q[g] <= 1'b0;
      else if (evt_i[g])          pend_q[g] <= 1'b1;
      else if (wr_i && ack_i[g])  pend_q[g] <= 1'b0;
    end
  end

  assign en_o   = en_q;
  assign pend_o = pend_q;
  assign irq_o  = |(en_q & pend_q);
endmodule

// File: rtl/nic_cs_run_ctrl.sv
module nic_cs_run_ctrl #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] on_o
);
  logic [N-1:0] on_q;

  for (genvar g = 0; g < N; g++) begin : g_run
    // clear beats set
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                on_q[g] <= 1'b0;
      else if (wr_i && clr_i[g])  on_q[g] <= 1'b0;
      else if (wr_i && set_i[g])  on_q[g] <= 1'b1;
    end
  end

  assign on_o = on_q;
endmodule

// File: rtl/nic_cs_fifo_dir.sv
module nic_cs_fifo_dir (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic to_rd_i,
  input  logic to_wr_i,
  output logic rd_dir_o
);
  logic rd_q;

  // write direction wins on conflict
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               rd_q <= 1'b0;
    else if (wr_i && to_wr_i)  rd_q <= 1'b0;
    else if (wr_i && to_rd_i)  rd_q <= 1'b1;
  end

  assign rd_dir_o = rd_q;
endmodule

// File: rtl/nic_cmd_stat.sv
module nic_cmd_stat
  import nic_cs_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cmd_wr_i,
  input  logic [WORD_W-1:0]   cmd_i,
  input  logic [NUM_SRC-1:0]  evt_i,
  input  logic                fifo_full_i,
  input  logic                fifo_empty_i,
  output logic [WORD_W-1:0]   status_o,
  output logic                irq_o,
  output logic [NUM_RUN-1:0]  run_on_o,
  output logic                fifo_rd_dir_o
);
  cmd_t  cmd;
  stat_t stat;
  logic [NUM_SRC-1:0] en, pend;
  logic [NUM_RUN-1:0] run_on;
  logic               rd_dir;

  assign cmd = cmd_t'(cmd_i);

  nic_cs_irq_bank #(.N(NUM_SRC)) i_irq_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (cmd_wr_i),
    .en_i   (cmd.en),
    .ack_i  (cmd.ack),
    .evt_i  (evt_i),
    .en_o   (en),
    .pend_o (pend),
    .irq_o  (irq_o)
  );

  nic_cs_run_ctrl #(.N(NUM_RUN)) i_run_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (cmd_wr_i),
    .set_i  (cmd.run_set),
    .clr_i  (cmd.run_clr),
    .on_o   (run_on)
  );

  nic_cs_fifo_dir i_fifo_dir (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (cmd_wr_i),
    .to_rd_i  (cmd.to_rd),
    .to_wr_i  (cmd.to_wr),
    .rd_dir_o (rd_dir)
  );

  always_comb begin
    stat        = '0;
    stat.en     = en;
    stat.pend   = pend;
    stat.run_on = run_on;
    stat.full   = fifo_full_i;
    stat.empty  = fifo_empty_i;
    stat.rd_dir = rd_dir;
  end

  assign status_o      = stat;
  assign run_on_o      = run_on;
  assign fifo_rd_dir_o = rd_dir;
endmodule

// File: rtl/nic_cs_chk.sv
module nic_cs_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cmd_wr_i,
  input logic [15:0] cmd_i,
  input logic [3:0]  evt_i,
  input logic [15:0] status_o,
  input logic        irq_o
);
  always @(posedge clk_i) begin
    if (!rst_ni)
      assert_reset_clear_R1: assert (status_o[10:0] == 11'd0 && !status_o[15] && !irq_o);
  end

  assert_en_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_wr_i |=> status_o[3:0] == $past(cmd_i[3:0]));

  for (genvar k = 0; k < 4; k++) begin : g_src
    assert_ack_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmd_wr_i && cmd_i[4+k] && !evt_i[k]) |=> !status_o[4+k]);
    assert_evt_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_i[k] |=> status_o[4+k]);
  end

  for (genvar k = 0; k < 3; k++) begin : g_run
    assert_clr_wins_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmd_wr_i && cmd_i[11+k]) |=> !status_o[8+k]);
    assert_set_on_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmd_wr_i && cmd_i[8+k] && !cmd_i[11+k]) |=> status_o[8+k]);
  end

  assert_dir_wr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr_i && cmd_i[15]) |=> !status_o[15]);
  assert_dir_rd_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr_i && cmd_i[14] && !cmd_i[15]) |=> status_o[15]);

  assert_gap_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[12:11] == 2'b00);

  assert_irq_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == |(status_o[7:4] & status_o[3:0]));

  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_wr_i |=> ($stable(status_o[3:0]) && $stable(status_o[10:8]) && $stable(status_o[15])));
endmodule

bind nic_cmd_stat nic_cs_chk i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cmd_wr_i (cmd_wr_i),
  .cmd_i    (cmd_i),
  .evt_i    (evt_i),
  .status_o (status_o),
  .irq_o    (irq_o)
);

// File: tb/test_nic_cmd_stat.sv
`timescale 1ns/1ps
module test_nic_cmd_stat;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_wr = 1'b0;
  logic [15:0] cmd = '0;
  logic [3:0]  evt = '0;
  logic        full = 1'b0;
  logic        empty = 1'b1;
  logic [15:0] status;
  logic        irq;
  logic [2:0]  run_on;
  logic        rd_dir;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  typedef struct {
    logic [15:0] st;
    logic        irq;
    string       req;
  } exp_t;
  exp_t q[$];

  logic [3:0] m_en = '0, m_pend = '0;
  logic [2:0] m_on = '0;
  logic       m_dir = 1'b0;

  always #5 clk = ~clk;

  nic_cmd_stat i_nic_cmd_stat (
    .clk_i         (clk),
    .rst_ni        (rst_ni),
    .cmd_wr_i      (cmd_wr),
    .cmd_i         (cmd),
    .evt_i         (evt),
    .fifo_full_i   (full),
    .fifo_empty_i  (empty),
    .status_o      (status),
    .irq_o         (irq),
    .run_on_o      (run_on),
    .fifo_rd_dir_o (rd_dir)
  );

  // driver: drive one cycle of stimulus, push the state expected after the next edge
  task automatic step(input logic wr, input logic [15:0] d, input logic [3:0] ev,
                      input logic f, input logic e, input string req);
    exp_t x;
    @(posedge clk);
    #2;
    cmd_wr = wr; cmd = d; evt = ev; full = f; empty = e;
    if (wr) begin
      m_en   = d[3:0];
      m_pend = m_pend & ~d[7:4];
      m_on   = (m_on | d[10:8]) & ~d[13:11];
      if (d[15])      m_dir = 1'b0;
      else if (d[14]) m_dir = 1'b1;
    end
    m_pend = m_pend | ev;
    x.st  = {m_dir, e, f, 2'b00, m_on, m_pend, m_en};
    x.irq = |(m_pend & m_en);
    x.req = req;
    q.push_back(x);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // monitor
  initial begin
    exp_t x;
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        x = q.pop_front();
        checks++;
        if (status !== x.st || irq !== x.irq || run_on !== x.st[10:8] || rd_dir !== x.st[15]) begin
          errors++;
          $display("FAIL %s: status=%h irq=%b expected status=%h irq=%b",
                   x.req, status, irq, x.st, x.irq);
        end
      end
    end
  end

  initial begin
    #((200000) * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete");
      summary();
      $finish;
    end
  end

  initial begin
    #12;
    checks++;
    if (status !== 16'h4000 || irq !== 1'b0) begin
      errors++;
      $display("FAIL R1: status=%h irq=%b expected status=4000 irq=0", status, irq);
    end
    #11 rst_ni = 1'b1;

    step(1, 16'h000F, 4'h0, 0, 1, "R2 load all enables");
    step(0, 16'h0000, 4'b0101, 0, 1, "R4 events dma and tx");
    step(1, 16'h0002, 4'h0, 0, 1, "R8 masked pending gives no irq");
    step(1, 16'h000F, 4'h0, 0, 1, "R8 unmasked pending raises irq");
    step(1, 16'h001F, 4'h0, 0, 1, "R3 ack dma only");
    step(1, 16'h004F, 4'b0100, 0, 1, "R4 event beats ack on tx");
    step(0, 16'h0000, 4'b1111, 0, 1, "R4 all events");
    step(1, 16'h00F0, 4'h0, 0, 1, "R3 0x00F0 clears all pending");
    step(1, 16'h0700, 4'h0, 0, 1, "R5 start all three");
    step(1, 16'h0800, 4'h0, 0, 1, "R5 stop dma");
    step(1, 16'h1200, 4'h0, 0, 1, "R5 set and clear rx together, clear wins");
    step(1, 16'h0300, 4'h0, 0, 1, "R5 restart dma and rx");
    step(1, 16'h3800, 4'h0, 0, 1, "R5 0x3800 stops all");
    step(1, 16'h4000, 4'h0, 0, 1, "R6 read direction");
    step(0, 16'h4000, 4'h0, 1, 0, "R7 fifo full, R9 hold");
    step(1, 16'h8000, 4'h0, 1, 1, "R6 write direction, R7 both flags");
    step(1, 16'h4000, 4'h0, 0, 0, "R6 back to read");
    step(1, 16'hC000, 4'h0, 0, 0, "R6 both bits, write wins");
    step(1, 16'h0508, 4'b1000, 0, 1, "R8 window source with enable");
    step(0, 16'hFFFF, 4'h0, 0, 1, "R9 no write: command ignored");
    step(0, 16'h0000, 4'h0, 0, 1, "R9 idle hold");
    repeat (3) @(posedge clk);
    done = 1;
    summary();
    $finish;
  end
endmodule